// File: doc/BRIEF.md
# Synchronous Transmit Frame Controller

This block is the transmit half of a byte-oriented synchronous serial controller. Bytes wait in a 32-entry transmit FIFO and leave on a single serial line, least significant bit first, one bit for each pulse of a transmit clock enable. Every frame closes with a 16-bit check sequence, and the line rests at logic 1 whenever no frame is being sent.

There are two ways to feed and bound a frame, chosen by a mode input. In CPU mode, software writes bytes into the FIFO and pulses a start command. A separate end command then says that the bytes written so far finish the frame. A pool-ready interrupt tells software when the FIFO has drained and needs more data. In DMA mode, software first loads a 16-bit byte count and then pulses start. The block then asks for bytes through a simple request/push port. Serial output begins once the FIFO is full or the whole count has been fetched, and the frame ends when the count has been sent. An abort command works in both modes: it empties the FIFO, drops the frame at once, idles the line and raises the pool-ready interrupt.

Top module: `sync_tx_framer`

## Requirements
- R1: While and after reset, `txd` is 1, `pool_irq` is 0 and `dma_req` is 0.
- R2: In CPU mode, after the end command and the start command, the FIFO bytes go out in write order. Each byte is sent bit 0 first, then the check sequence follows, and then the line stays at 1.
- R3: The check sequence is a CRC-16 with generator 0x8005 (x^16+x^15+x^2+1). It is cleared to zero when a frame starts, it is advanced by each data bit in the order that bit is sent, and it is sent bit 15 first.
- R4: The FIFO holds 32 bytes. A CPU write while the FIFO is full is dropped and does not change the bytes already stored.
- R5: A start command issued while a frame is in progress has no effect on that frame.
- R6: In CPU mode, `pool_irq` pulses for one cycle when a byte taken for sending leaves the FIFO empty and no end command is pending. It stays low when the FIFO empties with the end command pending.
- R7: An abort command empties the FIFO and ends any frame. In the next cycle `txd` is 1 and `pool_irq` pulses. A later frame carries only bytes written after the abort.
- R8: In DMA mode, `dma_req` is high only while bytes of the loaded count remain to be fetched and the FIFO is not full. A cycle with both `dma_req` and `dma_push` high stores `dma_data`.
- R9: In DMA mode, no data bit is sent until either the FIFO holds 32 bytes or the whole count has been fetched, whichever happens first.
- R10: In DMA mode, a frame ends with the check sequence after exactly the loaded count of bytes, and the end command is ignored.
- R11: Exactly one bit is sent for each cycle with `bit_en` high. `txd` holds its value in cycles where `bit_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_mode | input | 1 | 1 selects DMA mode, 0 selects CPU mode |
| bit_en | input | 1 | Transmit clock enable, one bit per high cycle |
| wr_en | input | 1 | CPU FIFO write strobe (CPU mode) |
| wr_data | input | 8 | CPU write byte |
| cnt_ld | input | 1 | Load the DMA byte count |
| cnt_val | input | 16 | DMA byte count value |
| cmd_xf | input | 1 | Start-frame command pulse |
| cmd_end | input | 1 | End-of-frame command pulse (CPU mode only) |
| cmd_rst | input | 1 | Transmitter abort command pulse |
| dma_req | output | 1 | Request for the next DMA byte |
| dma_push | input | 1 | DMA byte valid |
| dma_data | input | 8 | DMA byte |
| txd | output | 1 | Serial data line |
| pool_irq | output | 1 | Pool-ready interrupt pulse |

## Verification
The bench writes 33 bytes into a full FIFO. A design that let the extra byte wrap around would corrupt the first byte of the frame. It also repeats the start command in the middle of a frame, which a design that accepted it would show as a wrong check sequence. It holds back the last DMA byte of a short count to confirm the line stays idle, and it stops at 32 bytes of a longer count to confirm sending starts on a full FIFO. A design that waited for the count alone, or started early, would fail one of these two cases. It also checks that the interrupt fires once on a drain and not on the final drain after the end command, that an abort in mid-frame leaves no old byte in the next frame, and that a slow `bit_en` paces every bit.

// File: rtl/sync_tx_framer.sv
module sync_tx_framer #(
  parameter int DEPTH = 32,
  parameter int CW = 16,
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_mode,
  input  logic          bit_en,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          cnt_ld,
  input  logic [CW-1:0] cnt_val,
  input  logic          cmd_xf,
  input  logic          cmd_end,
  input  logic          cmd_rst,
  output logic          dma_req,
  input  logic          dma_push,
  input  logic [7:0]    dma_data,
  output logic          txd,
  output logic          pool_irq
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RUN, S_CRC} st_t;
  st_t st;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic [CW-1:0] len, fetch_left, send_left;
  logic [15:0]   shreg, crc;
  logic [4:0]    bits;
  logic          end_pend;

  logic full, empty, push_cpu, push_dma, push, shifting, need, last, load_crc, pop, irq_set;
  logic [15:0] crc_step, crc_nxt;

  assign full     = cnt == (AW+1)'(DEPTH);
  assign empty    = cnt == '0;
  assign dma_req  = dma_mode && (st == S_FILL || st == S_RUN) && fetch_left != '0 && !full;
  assign push_cpu = !dma_mode && wr_en && !full;
  assign push_dma = dma_push && dma_req;
  assign push     = push_cpu || push_dma;
  assign shifting = bit_en && bits != '0;
  assign need     = bits == '0 || (bits == 5'd1 && bit_en);
  assign last     = dma_mode ? (send_left == '0) : (empty && end_pend);
  assign load_crc = st == S_RUN && need && last;
  assign pop      = st == S_RUN && need && !last && !empty;
  assign crc_step = {crc[14:0], 1'b0} ^ ((crc[15] ^ shreg[0]) ? POLY : 16'h0000);
  assign crc_nxt  = (st == S_RUN && shifting) ? crc_step : crc;
  assign irq_set  = !dma_mode && pop && cnt == (AW+1)'(1) && !push && !end_pend && !cmd_end;
  assign txd      = (bits != '0) ? ((st == S_CRC) ? shreg[15] : shreg[0]) : 1'b1;

  always_ff @(posedge clk)
    if (push) mem[wp] <= push_dma ? dma_data : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_rst) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      st <= S_IDLE;
      bits <= '0;
      shreg <= '0;
      crc <= '0;
      end_pend <= 1'b0;
      fetch_left <= '0;
      send_left <= '0;
      pool_irq <= rst_n;
      if (!rst_n) len <= '0;
    end else begin
      pool_irq <= irq_set;
      if (cnt_ld) len <= cnt_val;
      if (push) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      if (push_dma) fetch_left <= fetch_left - 1'b1;
      if (!dma_mode && cmd_end) end_pend <= 1'b1;
      crc <= crc_nxt;

      if (load_crc) begin
        shreg <= crc_nxt;
        bits <= 5'd16;
        st <= S_CRC;
        end_pend <= 1'b0;
      end else if (pop) begin
        shreg <= {8'h00, mem[rp]};
        bits <= 5'd8;
        if (dma_mode) send_left <= send_left - 1'b1;
      end else if (st == S_CRC && need) begin
        bits <= '0;
        st <= S_IDLE;
      end else if (shifting) begin
        shreg <= (st == S_CRC) ? {shreg[14:0], 1'b0} : {1'b0, shreg[15:1]};
        bits <= bits - 5'd1;
      end

      case (st)
        S_IDLE:
          if (cmd_xf) begin
            crc <= '0;
            if (dma_mode) begin
              fetch_left <= len;
              send_left <= len;
              st <= S_FILL;
            end else begin
              st <= S_RUN;
            end
          end
        S_FILL:
          if (full || fetch_left == '0) st <= S_RUN;
        default: ;
      endcase
    end
  end
endmodule

module sync_tx_framer_chk #(
  parameter int DEPTH = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bit_en,
  input logic                   cmd_rst,
  input logic                   dma_mode,
  input logic                   txd,
  input logic                   pool_irq,
  input logic                   dma_req,
  input logic [$clog2(DEPTH):0] fifo_cnt,
  input logic [4:0]             bits_left,
  input logic                   st_idle
);
  assert_fifo_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_req_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_mode && fifo_cnt < ($clog2(DEPTH)+1)'(DEPTH)));

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> txd);

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (txd && pool_irq && fifo_cnt == '0));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pool_irq |-> ($past(cmd_rst) || !$past(dma_mode)));

  assert_bit_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && bits_left != '0 && !cmd_rst) |=> $stable(txd));
endmodule

bind sync_tx_framer sync_tx_framer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cmd_rst(cmd_rst), .dma_mode(dma_mode),
  .txd(txd), .pool_irq(pool_irq), .dma_req(dma_req), .fifo_cnt(cnt),
  .bits_left(bits), .st_idle(st == S_IDLE)
);

// File: tb/sync_tx_framer_test.sv
module sync_tx_framer_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, dma_mode = 1'b0, wr_en = 1'b0, cnt_ld = 1'b0;
  logic cmd_xf = 1'b0, cmd_end = 1'b0, cmd_rst = 1'b0, dma_push = 1'b0;
  logic [7:0] wr_data = 8'h00, dma_data = 8'h00;
  logic [15:0] cnt_val = 16'h0000;
  logic bit_en, dma_req, txd, pool_irq;
  logic slow = 1'b0;
  logic [1:0] div = 2'd0;

  always @(posedge clk) div <= (div == 2'd2) ? 2'd0 : div + 2'd1;
  assign bit_en = slow ? (div == 2'd0) : 1'b1;

  sync_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .bit_en(bit_en),
    .wr_en(wr_en), .wr_data(wr_data), .cnt_ld(cnt_ld), .cnt_val(cnt_val),
    .cmd_xf(cmd_xf), .cmd_end(cmd_end), .cmd_rst(cmd_rst),
    .dma_req(dma_req), .dma_push(dma_push), .dma_data(dma_data),
    .txd(txd), .pool_irq(pool_irq)
  );

  int n_chk = 0, n_fail = 0;
  logic cap = 1'b0;
  logic rec [0:511];
  int nb = 0, irq_cnt = 0;
  logic [7:0] eb [0:63];
  int ebn = 0;

  always @(negedge clk) begin
    if (pool_irq) irq_cnt++;
    if (cap && bit_en && nb < 512 && (nb > 0 || txd == 1'b0)) begin
      rec[nb] = txd;
      nb++;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_crc();
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < ebn; i++)
      for (int b = 0; b < 8; b++)
        c = {c[14:0], 1'b0} ^ ((c[15] ^ eb[i][b]) ? 16'h8005 : 16'h0000);
    return c;
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(logic [7:0] b);
    wr_en = 1'b1; wr_data = b; tick(); wr_en = 1'b0;
  endtask

  task automatic pulse_xf();  cmd_xf = 1'b1;  tick(); cmd_xf = 1'b0;  endtask
  task automatic pulse_end(); cmd_end = 1'b1; tick(); cmd_end = 1'b0; endtask

  task automatic start_cap();
    nb = 0; cap = 1'b1;
  endtask

  task automatic push_dma(logic [7:0] b);
    int t = 0;
    while (!dma_req && t < 2000) begin tick(); t++; end
    dma_push = 1'b1; dma_data = b; tick(); dma_push = 1'b0;
  endtask

  task automatic frame_check(string rd, string rc);
    int total = 8 * ebn + 16;
    int t = 0, derr = 0, cerr = 0, ones = 0;
    logic [15:0] c = exp_crc();
    while (nb < total + 20 && t < 20000) begin tick(); t++; end
    check(rd, "frame bits seen", (nb >= total + 20) ? 1 : 0, 1);
    for (int k = 0; k < 8 * ebn; k++)
      if (rec[k] !== eb[k / 8][k % 8]) derr++;
    for (int k = 0; k < 16; k++)
      if (rec[8 * ebn + k] !== c[15 - k]) cerr++;
    for (int k = total; k < total + 20; k++)
      if (rec[k] === 1'b1) ones++;
    check(rd, "data bit errors", derr, 0);
    check(rc, "crc bit errors", cerr, 0);
    check(rd, "idle ones after frame", ones, 20);
    cap = 1'b0;
  endtask

  task automatic t_reset();
    tick(3);
    check("R1", "txd in reset", txd, 1);
    check("R1", "irq in reset", pool_irq, 0);
    check("R1", "req in reset", dma_req, 0);
    rst_n = 1'b1; tick(2);
    check("R1", "txd after reset", txd, 1);
    check("R1", "irq after reset", pool_irq, 0);
    check("R1", "req after reset", dma_req, 0);
  endtask

  task automatic t_basic();
    ebn = 3; eb[0] = 8'hA6; eb[1] = 8'h3C; eb[2] = 8'hF1;
    for (int i = 0; i < ebn; i++) wr_byte(eb[i]);
    pulse_end();
    start_cap();
    pulse_xf();
    tick(12);
    pulse_xf();
    frame_check("R2", "R3");
    check("R5", "second start left no extra bits", nb - (8 * ebn + 16), 20);
  endtask

  task automatic t_full();
    ebn = 32;
    for (int i = 0; i < ebn; i++) eb[i] = 8'(i * 29 + 4);
    for (int i = 0; i < ebn; i++) wr_byte(eb[i]);
    wr_byte(8'hFF);
    pulse_end();
    start_cap();
    pulse_xf();
    frame_check("R4", "R3");
  endtask

  task automatic t_irq();
    irq_cnt = 0;
    wr_byte(8'h18); wr_byte(8'h77);
    pulse_xf();
    tick(60);
    check("R6", "irq pulses on drain", irq_cnt, 1);
    cmd_end = 1'b1; wr_en = 1'b1; wr_data = 8'h5E; tick();
    cmd_end = 1'b0; wr_en = 1'b0;
    tick(80);
    check("R6", "irq pulses after final drain", irq_cnt, 1);
    check("R6", "line idle after frame", txd, 1);
  endtask

  task automatic t_abort();
    int t = 0, ones = 0;
    for (int i = 0; i < 4; i++) wr_byte(8'(8'h10 + i * 2));
    start_cap();
    pulse_xf();
    while (nb < 5 && t < 200) begin tick(); t++; end
    cap = 1'b0;
    irq_cnt = 0;
    cmd_rst = 1'b1; tick(); cmd_rst = 1'b0;
    check("R7", "txd after abort", txd, 1);
    check("R7", "irq after abort", pool_irq, 1);
    for (int i = 0; i < 30; i++) begin tick(); if (txd) ones++; end
    check("R7", "line idle after abort", ones, 30);
    check("R7", "irq pulse count", irq_cnt, 1);
    ebn = 2; eb[0] = 8'h42; eb[1] = 8'h99;
    for (int i = 0; i < ebn; i++) wr_byte(eb[i]);
    pulse_end();
    start_cap();
    pulse_xf();
    frame_check("R7", "R3");
  endtask

  task automatic t_dma_small();
    ebn = 5; eb[0] = 8'h6C; eb[1] = 8'h11; eb[2] = 8'h80; eb[3] = 8'h3F; eb[4] = 8'hE2;
    dma_mode = 1'b1;
    cnt_val = 16'd5; cnt_ld = 1'b1; tick(); cnt_ld = 1'b0;
    start_cap();
    pulse_xf();
    for (int i = 0; i < 4; i++) push_dma(eb[i]);
    tick(100);
    check("R9", "no bits before count fetched", nb, 0);
    check("R8", "req while count remains", dma_req, 1);
    push_dma(eb[4]);
    check("R8", "req after count fetched", dma_req, 0);
    tick(10);
    pulse_end();
    frame_check("R10", "R3");
    check("R8", "req idle after frame", dma_req, 0);
  endtask

  task automatic t_dma_big();
    int t = 0;
    ebn = 40;
    for (int i = 0; i < ebn; i++) eb[i] = 8'(i * 53 + 2);
    cnt_val = 16'd40; cnt_ld = 1'b1; tick(); cnt_ld = 1'b0;
    start_cap();
    pulse_xf();
    for (int i = 0; i < 32; i++) push_dma(eb[i]);
    check("R8", "req with full fifo", dma_req, 0);
    while (nb == 0 && t < 60) begin tick(); t++; end
    check("R9", "sending starts at full fifo", (nb > 0) ? 1 : 0, 1);
    for (int i = 32; i < 40; i++) push_dma(eb[i]);
    frame_check("R9", "R3");
    dma_mode = 1'b0;
  endtask

  task automatic t_slow();
    slow = 1'b1;
    ebn = 2; eb[0] = 8'h2E; eb[1] = 8'hC5;
    for (int i = 0; i < ebn; i++) wr_byte(eb[i]);
    pulse_end();
    start_cap();
    pulse_xf();
    frame_check("R11", "R3");
    slow = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_full();
    t_irq();
    t_abort();
    t_dma_small();
    t_dma_big();
    t_slow();
    summary();
    $finish;
  end
endmodule